// File: doc/BRIEF.md
# Signed Successive-Approximation Register

This block is the digital search engine of a bipolar successive-approximation converter. A sequencer pulses `start` once the analog sample is held. The block first drives an all-zero trial code so the comparator can judge the sample against ground, and that decision becomes the sign. It then runs a binary search over the magnitude bits, one decision per clock, from the most significant bit down. On each step it sets the next bit of the trial code on top of the bits already kept, and keeps that bit only if the comparator reports the input above the DAC level.

The trial code is a two's complement number whose top bit is the sign just found. A negative input is therefore searched upward from the most negative level. The finished word is already in two's complement form and needs no conversion. After the last decision the word is written into a result register that changes at no other time. A single-cycle `done` pulse marks the update.

Top module: `signed_sar`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `busy`, `done`, `trial_code` and `result` are all zero.
- R2: A `start` seen while idle raises `busy` on the next cycle. A `start` while `busy` is high is ignored and changes neither the trial sequence nor the timing.
- R3: During the first busy cycle (the sign step) `trial_code` is all zeros.
- R4: The sign bit, which is the top bit of the word, is 0 when `cmp_hi` is 1 in the sign step (input above ground) and 1 otherwise.
- R5: In the second busy cycle `trial_code` holds the sign in its top bit, a 1 in the magnitude MSB (bit MAG_W-1) and zeros below.
- R6: On each magnitude step the trial bit is kept if `cmp_hi` is 1 and cleared if it is 0. The next trial code is the kept bits plus a 1 in the next lower position, down to bit 0.
- R7: `done` is high for exactly one cycle, MAG_W+1 cycles after the edge that accepted `start`, and `busy` falls in that same cycle.
- R8: `result` changes only in the cycle in which `done` is high.
- R9: `result` is the two's complement code of the input, with bit MAG_W as the sign and bit 0 as the LSB. For an input between codes c and c+1 it equals c, so the full-scale extremes give the minimum code (only the sign set) and the maximum code (all bits set except the sign).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (ignored while busy) |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is above the DAC level |
| trial_code | output | MAG_W+1 | Two's complement code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | MAG_W+1 | Latched two's complement conversion result |

## Verification
On every cycle the assertions check several properties. `done` is a single-cycle pulse that follows a magnitude step. The step pointer is one-hot during the search. A busy conversion cannot be cut short by a stray `start`. The sign bit holds through the magnitude steps. The first magnitude trial is the lone MSB. `result` holds between loads. Only the bench can show that the decided codes match the input: its comparator model responds to the trial code, and it checks the trial sequence step by step and the final value, including the full-scale extremes and the values on either side of zero. It also shows the exact latency.

// File: rtl/ssar_pkg.sv
package ssar_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SIGN = 2'd1,
      PH_MAG  = 2'd2
   } ssar_phase_e;

   function automatic int unsigned ssar_cycles(input int unsigned mag_w);
      return mag_w + 1;
   endfunction

endpackage

// File: rtl/ssar_step_ctrl.sv
module ssar_step_ctrl
   import ssar_pkg::*;
#(
   parameter int unsigned MAG_W       = 12,
   parameter bit          STEP_ONEHOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output ssar_phase_e      phase,
   output logic [MAG_W-1:0] bit_sel,
   output logic             last,
   output logic             done
);

   localparam int unsigned CNT_W = (MAG_W > 1) ? $clog2(MAG_W) : 1;

   ssar_phase_e phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase_q)
            PH_IDLE: if (start) phase_q <= PH_SIGN;
            PH_SIGN: phase_q <= PH_MAG;
            PH_MAG: begin
               if (last) begin
                  phase_q <= PH_IDLE;
                  done    <= 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;

   generate
      if (STEP_ONEHOT) begin : g_onehot
         logic [MAG_W-1:0] sel_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sel_q <= '0;
            end else if (phase_q == PH_SIGN) begin
               sel_q <= {1'b1, {(MAG_W-1){1'b0}}};
            end else if (phase_q == PH_MAG) begin
               sel_q <= sel_q >> 1;
            end
         end
         assign bit_sel = sel_q;
         assign last    = (phase_q == PH_MAG) && sel_q[0];
      end else begin : g_count
         logic [CNT_W-1:0] idx_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               idx_q <= '0;
            end else if (phase_q == PH_SIGN) begin
               idx_q <= CNT_W'(MAG_W-1);
            end else if (phase_q == PH_MAG && idx_q != '0) begin
               idx_q <= idx_q - 1'b1;
            end
         end
         assign bit_sel = (phase_q == PH_MAG) ? (MAG_W'(1) << idx_q) : '0;
         assign last    = (phase_q == PH_MAG) && (idx_q == '0);
      end
   endgenerate

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_AFTER_MAG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(phase_q) == PH_MAG)); // R7
   AST_SEL_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_MAG) |-> ($countones(bit_sel) == 1)); // R6
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && !last) |=> (phase_q != PH_IDLE)); // R2

endmodule

// File: rtl/ssar_bit_reg.sv
module ssar_bit_reg
   import ssar_pkg::*;
#(
   parameter int unsigned MAG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ssar_phase_e      phase,
   input  logic [MAG_W-1:0] bit_sel,
   input  logic             cmp_hi,
   output logic             sign_q,
   output logic [MAG_W-1:0] mag_q,
   output logic [MAG_W:0]   trial
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sign_q <= 1'b0;
      end else if (phase == PH_SIGN) begin
         sign_q <= ~cmp_hi;
      end
   end

   generate
      for (genvar i = 0; i < MAG_W; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (phase == PH_SIGN) begin
               bit_q <= 1'b0;
            end else if (phase == PH_MAG && bit_sel[i]) begin
               bit_q <= cmp_hi;
            end
         end
         assign mag_q[i] = bit_q;
      end
   endgenerate

   always_comb begin
      trial = '0;
      if (phase == PH_MAG) begin
         trial = {sign_q, mag_q | bit_sel};
      end
   end

   AST_SIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MAG && $past(phase) == PH_MAG) |-> $stable(sign_q)); // R4
   AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MAG && $past(phase) == PH_SIGN)
         |-> (trial[MAG_W-1:0] == {1'b1, {(MAG_W-1){1'b0}}})); // R5

endmodule

// File: rtl/ssar_result_reg.sv
module ssar_result_reg #(
   parameter int unsigned WIDTH = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

   AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q)); // R8

endmodule

// File: rtl/signed_sar.sv
module signed_sar
   import ssar_pkg::*;
#(
   parameter int unsigned MAG_W       = 12,
   parameter bit          STEP_ONEHOT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           cmp_hi,
   output logic [MAG_W:0] trial_code,
   output logic           busy,
   output logic           done,
   output logic [MAG_W:0] result
);

   localparam int unsigned WORD_W = MAG_W + 1;

   generate
      if (MAG_W < 2 || MAG_W > 30) begin : g_bad_width
         $error("signed_sar: MAG_W must lie in 2..30");
      end
      if (ssar_cycles(MAG_W) != WORD_W) begin : g_bad_cycles
         $error("signed_sar: cycle count mismatch");
      end
   endgenerate

   ssar_phase_e      phase;
   logic [MAG_W-1:0] bit_sel;
   logic             last;
   logic             sign_q;
   logic [MAG_W-1:0] mag_q;
   logic [WORD_W-1:0] final_word;

   ssar_step_ctrl #(
      .MAG_W       (MAG_W),
      .STEP_ONEHOT (STEP_ONEHOT)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .phase   (phase),
      .bit_sel (bit_sel),
      .last    (last),
      .done    (done)
   );

   ssar_bit_reg #(
      .MAG_W (MAG_W)
   ) u_bits (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (phase),
      .bit_sel (bit_sel),
      .cmp_hi  (cmp_hi),
      .sign_q  (sign_q),
      .mag_q   (mag_q),
      .trial   (trial_code)
   );

   assign final_word = {sign_q, (mag_q & ~bit_sel) | ({MAG_W{cmp_hi}} & bit_sel)};

   ssar_result_reg #(
      .WIDTH (WORD_W)
   ) u_result (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (last),
      .d     (final_word),
      .q     (result)
   );

   assign busy = (phase != PH_IDLE);

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy); // R2

endmodule

// File: tb/signed_sar_bench.sv
`timescale 1ns/1ps
module signed_sar_bench;

   localparam int MAG_W = 12;
   localparam int W     = MAG_W + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         cmp_hi;
   logic [W-1:0] trial_code;
   logic         busy;
   logic         done;
   logic [W-1:0] result;

   int ain = 1;  // analog input in half-LSB units, always odd
   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   // Comparator model: input above DAC level of the trial code.
   assign cmp_hi = (2 * int'($signed(trial_code))) < ain;

   signed_sar u_signed_sar (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cmp_hi     (cmp_hi),
      .trial_code (trial_code),
      .busy       (busy),
      .done       (done),
      .result     (result)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h (ain=%0d)", req, act, exp, ain);
      end
   endtask

   function automatic logic [W-1:0] expect_code(input int a);
      int v;
      v = (a - 1) / 2;
      return W'(v);
   endfunction

   task automatic convert(input int a, input bit poke_busy);
      logic [W-1:0] prev;
      logic         s;
      logic [MAG_W-1:0] dec;
      logic [W-1:0] exp_trial;
      ain = a;
      prev = result;
      s = (a > 0) ? 1'b0 : 1'b1;
      dec = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // j = 1: one cycle after the accepting edge
      chk(busy == 1'b1, "R2 busy", int'(busy), 1);
      chk(trial_code == '0, "R3 sign trial", int'(trial_code), 0);
      chk(done == 1'b0, "R7 no early done", int'(done), 0);
      for (int j = 2; j <= MAG_W + 1; j++) begin
         @(negedge clk);
         exp_trial = {s, dec | (MAG_W'(1) << (MAG_W + 1 - j))};
         if (j == 2)
            chk(trial_code == exp_trial, "R5 first magnitude trial", int'(trial_code), int'(exp_trial));
         else
            chk(trial_code == exp_trial, "R6 trial step", int'(trial_code), int'(exp_trial));
         chk(done == 1'b0 && busy == 1'b1, "R7 busy no done", int'({busy, done}), 2);
         chk(result == prev, "R8 result held", int'(result), int'(prev));
         if ((2 * int'($signed(exp_trial))) < a)
            dec = dec | (MAG_W'(1) << (MAG_W + 1 - j));
         if (poke_busy && j == 5) start = 1'b1;
         if (poke_busy && j == 6) start = 1'b0;
      end
      @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, "R7 done pulse", int'({busy, done}), 1);
      chk(result[W-1] == s, "R4 sign bit", int'(result[W-1]), int'(s));
      chk(result == expect_code(a), "R9 result code", int'(result), int'(expect_code(a)));
      if (poke_busy)
         chk(result == expect_code(a), "R2 start while busy ignored", int'(result), int'(expect_code(a)));
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
      chk(result == expect_code(a), "R8 result stays", int'(result), int'(expect_code(a)));
   endtask

   initial begin
      int a;
      void'($urandom(32'h5A5A_1234));
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'({busy, done}), 0);
      chk(trial_code == '0 && result == '0, "R1 reset data", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && result == '0 && trial_code == '0, "R1 after reset", int'(result), 0);

      convert(8191, 1'b0);   // top of range
      convert(-8191, 1'b0);  // bottom of range
      convert(1, 1'b0);      // just above zero
      convert(-1, 1'b0);     // just below zero
      convert(2731, 1'b1);   // start pulsed mid-conversion
      convert(-4097, 1'b0);
      for (int i = 0; i < 60; i++) begin
         a = int'($urandom_range(0, 8190)) * 2 - 8189;
         convert(a, (i % 7) == 3);
      end
      // idle with start low: nothing moves
      repeat (4) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R2 stays idle", int'({busy, done}), 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule